// File: doc/BRIEF.md
# Interrupt Source Conditioning and Fast Request Path

This block takes a bank of interrupt inputs and turns each one into a clean per-source pending bit. It then sends every enabled pending source to one of two request lines. Each source can be level-sensitive or edge-triggered. The lower-indexed pins come from outside the chip, so they pass through a synchronizer and may be set to either polarity. The remaining inputs come from on-chip peripherals and always read as active-high, or rising edge in edge mode. When a source is edge-triggered, an edge sets a sticky latch, and that latch stays set until the request is acknowledged.

Any source can be steered onto the fast request line. That line has no priority levels: it is simply the OR of every enabled, pending, fast-steered source. Every other enabled source goes out as a bit on a normal request vector, which feeds a separate arbiter. That arbiter acknowledges a source by presenting its index on an acknowledge port, and the acknowledge clears the source's edge latch.

Software reaches the block through a small word-addressed register port. Enable bits change through separate set and clear registers, so one store can enable or disable sources without a read-modify-write. Reading the fast-vector register returns a stored handler address. The same read clears the edge latches of all enabled, fast-steered sources.

Top module: `irq_src_cond`

## Requirements
- R1: After reset, the trigger-mode, polarity, fast-steer and enable registers and the fast vector all read 0, and both `fastIrq` and `normIrq` are low.
- R2: A level-sensitive external source becomes pending two clock edges after its pin changes. An internal level source is pending in the same cycle its input is high.
- R3: Polarity register (address 1): a 1 makes an external source active-low, or falling-edge in edge mode. Polarity bits of internal sources (index NUM_EXT and above) are stored as 0, read as 0 and have no effect.
- R4: Trigger-mode register (address 0): a 1 selects edge mode. An active edge sets a latch that keeps the source pending after its input returns. For an internal source the latch is set at the first clock edge; for an external source it is set at the third clock edge after the pin change.
- R5: Writing ones to the enable-set register (address 3) enables those sources. Writing ones to the enable-clear register (address 4) disables them. Bits written as 0 leave their sources unchanged. The mask register (address 5) reads back the enable bits.
- R6: Fast-steer register (address 2). `fastIrq` is the OR of every source that is pending, enabled and fast-steered. `normReq` carries only the sources that are pending, enabled and not fast-steered. `normIrq` is the OR of `normReq`.
- R7: The pending register (address 6) shows the conditioned request of every source, whether or not it is enabled.
- R8: Address 7 holds the fast vector. A read returns the last value written there. The same read clears the edge latches of enabled, fast-steered sources, and leaves level sources and normal sources unchanged.
- R9: A pulse on `ackEn` with source index `ackId` clears that source's edge latch.
- R10: If a new active edge arrives in the same cycle as a clear of its latch, the latch stays set.
- R11: Read data appears on `rdData` in the cycle after `rdEn`. In a cycle that follows no read, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Raw interrupt inputs; indices below NUM_EXT are external pins |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| ackEn | input | 1 | Acknowledge strobe from the normal-line arbiter |
| ackId | input | $clog2(NUM_SRC) | Index of the acknowledged source |
| fastIrq | output | 1 | Fast request line |
| normIrq | output | 1 | Normal request line |
| normReq | output | NUM_SRC | Per-source normal requests for the arbiter |

## Verification
The request outputs are combinational from state, so their timing follows from the registers in front of them. An internal level source is seen in the same cycle, and an internal edge one edge later. An external level source is seen after two edges, and an external edge after three. Register writes take effect at the edge that samples them, and read data follows one edge after `rdEn`. The bench drives every input on a falling clock edge and samples on later falling edges, counted to those latencies. For external pins it checks both one cycle early (still quiet) and exactly on time. This catches a synchronizer that is too short or too long, as well as a missing edge register.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_W = 3;

  // word map of the register port
  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG   = 3'd0,
    REG_POL    = 3'd1,
    REG_FAST   = 3'd2,
    REG_EN_SET = 3'd3,
    REG_EN_CLR = 3'd4,
    REG_MASK   = 3'd5,
    REG_PEND   = 3'd6,
    REG_FVEC   = 3'd7
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrTrig;
    logic    wrPol;
    logic    wrFast;
    logic    wrEnSet;
    logic    wrEnClr;
    logic    wrFvec;
    logic    rdStrobe;
    logic    rdFvec;
    regSel_e rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/irq_cond_ctrl.sv
module irq_cond_ctrl
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ackEn,
  input  logic [ID_W-1:0]   ackId,
  output ctrlStb_t          stb,
  output logic [NUM_SRC-1:0] ackHit
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [ID_W:0] SRC_LIM = (ID_W+1)'(NUM_SRC);

  regSel_e sel;
  assign sel = regSel_e'(addr);

  always_comb begin
    stb          = '0;
    stb.wrTrig   = wrEn && (sel == REG_TRIG);
    stb.wrPol    = wrEn && (sel == REG_POL);
    stb.wrFast   = wrEn && (sel == REG_FAST);
    stb.wrEnSet  = wrEn && (sel == REG_EN_SET);
    stb.wrEnClr  = wrEn && (sel == REG_EN_CLR);
    stb.wrFvec   = wrEn && (sel == REG_FVEC);
    stb.rdStrobe = rdEn;
    stb.rdFvec   = rdEn && (sel == REG_FVEC);
    stb.rdSel    = sel;
  end

  // one-hot acknowledge decode, out-of-range indices are dropped
  always_comb begin
    ackHit = '0;
    if (ackEn && ({1'b0, ackId} < SRC_LIM)) ackHit[ackId] = 1'b1;
  end
endmodule

// File: rtl/irq_cond_dp.sv
module irq_cond_dp
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_EXT     = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] ackHit,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] normReq,
  output logic               normIrq,
  output logic               fastIrq
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [NUM_SRC-1:0] trigQ, polQ, fastQ, maskQ;
  logic [NUM_SRC-1:0] condNow, condPrev, edgeQ, edgeHit, edgeClr;
  logic [NUM_SRC-1:0] pendVec, activeVec, extAllow, wrBits;
  logic [DATA_W-1:0]  fvecQ, rdNext;

  assign wrBits = wrData[NUM_SRC-1:0];

  // per-source input conditioning
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_EXT) begin : g_ext
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], srcIn[i]};
      end
      assign condNow[i]  = syncQ[SYNC_STAGES-1] ^ polQ[i];
      assign extAllow[i] = 1'b1;
    end else begin : g_int
      assign condNow[i]  = srcIn[i];
      assign extAllow[i] = 1'b0;
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ <= '0;
      polQ  <= '0;
      fastQ <= '0;
      maskQ <= '0;
      fvecQ <= '0;
    end else begin
      if (stb.wrTrig)  trigQ <= wrBits;
      if (stb.wrPol)   polQ  <= wrBits & extAllow;
      if (stb.wrFast)  fastQ <= wrBits;
      if (stb.wrEnSet) maskQ <= maskQ | wrBits;
      if (stb.wrEnClr) maskQ <= maskQ & ~wrBits;
      if (stb.wrFvec)  fvecQ <= wrData;
    end
  end

  // edge detection and sticky latch; a new edge beats a clear
  assign edgeHit = trigQ & condNow & ~condPrev;
  assign edgeClr = ackHit | (stb.rdFvec ? (fastQ & maskQ) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= '0;
      edgeQ    <= '0;
    end else begin
      condPrev <= condNow;
      edgeQ    <= (edgeHit | (edgeQ & ~edgeClr)) & trigQ;
    end
  end

  assign pendVec   = (trigQ & edgeQ) | (~trigQ & condNow);
  assign activeVec = pendVec & maskQ;
  assign fastIrq   = |(activeVec & fastQ);
  assign normReq   = activeVec & ~fastQ;
  assign normIrq   = |normReq;

  // registered read port
  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      REG_TRIG: rdNext[NUM_SRC-1:0] = trigQ;
      REG_POL:  rdNext[NUM_SRC-1:0] = polQ;
      REG_FAST: rdNext[NUM_SRC-1:0] = fastQ;
      REG_MASK: rdNext[NUM_SRC-1:0] = maskQ;
      REG_PEND: rdNext[NUM_SRC-1:0] = pendVec;
      REG_FVEC: rdNext              = fvecQ;
      default:  rdNext              = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (stb.rdStrobe) rdData <= rdNext;
    else                   rdData <= '0;
  end
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_EXT     = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               ackEn,
  input  logic [ID_W-1:0]    ackId,
  output logic               fastIrq,
  output logic               normIrq,
  output logic [NUM_SRC-1:0] normReq
);
  timeunit 1ns;
  timeprecision 100ps;

  ctrlStb_t           stb;
  logic [NUM_SRC-1:0] ackHit;

  irq_cond_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .ackEn  (ackEn),
    .ackId  (ackId),
    .stb    (stb),
    .ackHit (ackHit)
  );

  irq_cond_dp #(
    .NUM_SRC     (NUM_SRC),
    .NUM_EXT     (NUM_EXT),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .ackHit  (ackHit),
    .rdData  (rdData),
    .normReq (normReq),
    .normIrq (normIrq),
    .fastIrq (fastIrq)
  );
endmodule

// File: rtl/irq_src_cond_chk.sv
module irq_src_cond_chk
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_EXT = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               fastIrq,
  input logic               normIrq,
  input logic [NUM_SRC-1:0] normReq,
  input ctrlStb_t           stb
);
  timeunit 1ns;
  timeprecision 100ps;

  AST_WR_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrTrig, stb.wrPol, stb.wrFast, stb.wrEnSet, stb.wrEnClr, stb.wrFvec})); // R5

  AST_CLR_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_EN_CLR && wrData[NUM_SRC-1:0] == '1)
      |=> (!fastIrq && !normIrq && normReq == '0)); // R6

  AST_FAST_ALL_NO_NORM: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_FAST && wrData[NUM_SRC-1:0] == '1)
      |=> (normReq == '0 && !normIrq)); // R6

  AST_FVEC_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_FVEC) ##1 (rdEn && !wrEn && addr == REG_FVEC)
      |=> rdData == $past(wrData, 2)); // R8

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == '0); // R11

  if (NUM_EXT < NUM_SRC) begin : g_pol
    AST_INT_POL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && addr == REG_POL) |=> rdData[NUM_SRC-1:NUM_EXT] == '0); // R3
  end
endmodule

bind irq_src_cond irq_src_cond_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_EXT (NUM_EXT),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/test_irq_src_cond.sv
module test_irq_src_cond;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] srcIn;
  logic        wrEn, rdEn, ackEn;
  logic [2:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [4:0]  ackId;
  logic        fastIrq, normIrq;
  logic [31:0] normReq;

  int nChk = 0;
  int nErr = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  irq_src_cond i_irq_src_cond (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ackEn(ackEn),
    .ackId(ackId), .fastIrq(fastIrq), .normIrq(normIrq), .normReq(normReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic ack(input logic [4:0] id);
    @(negedge clk); ackEn = 1'b1; ackId = id;
    @(negedge clk); ackEn = 1'b0;
  endtask

  task automatic cleanSlate();
    wr(3'd0, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h0);
    srcIn = '0;
    step(4);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 fastIrq", {31'b0, fastIrq}, 32'h0);
    chk("R1 normIrq", {31'b0, normIrq}, 32'h0);
    rd(3'd0, d); chk("R1 trig", d, 32'h0);
    rd(3'd1, d); chk("R1 pol", d, 32'h0);
    rd(3'd2, d); chk("R1 fast", d, 32'h0);
    rd(3'd5, d); chk("R1 mask", d, 32'h0);
    rd(3'd7, d); chk("R1 fvec", d, 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] d;
    wr(3'd3, 32'h0000_00F0); rd(3'd5, d); chk("R5 set F0", d, 32'h0000_00F0);
    wr(3'd3, 32'h0000_0003); rd(3'd5, d); chk("R5 set adds", d, 32'h0000_00F3);
    wr(3'd4, 32'h0000_0011); rd(3'd5, d); chk("R5 clr", d, 32'h0000_00E2);
    wr(3'd4, 32'h0000_0000); rd(3'd5, d); chk("R5 clr zero", d, 32'h0000_00E2);
  endtask

  task automatic testExtLevel();
    cleanSlate();
    wr(3'd2, 32'h1); wr(3'd3, 32'h1);
    @(negedge clk); srcIn[0] = 1'b1;
    @(negedge clk); chk("R2 ext level early", {31'b0, fastIrq}, 32'h0);
    @(negedge clk); chk("R2 ext level on time", {31'b0, fastIrq}, 32'h1);
    chk("R6 fast not normal", {31'b0, normIrq}, 32'h0);
    srcIn[0] = 1'b0;
    @(negedge clk); chk("R2 ext fall early", {31'b0, fastIrq}, 32'h1);
    @(negedge clk); chk("R2 ext fall on time", {31'b0, fastIrq}, 32'h0);
  endtask

  task automatic testPolarity();
    logic [31:0] d;
    cleanSlate();
    wr(3'd1, 32'h0000_0102);
    rd(3'd1, d); chk("R3 internal pol reads 0", d, 32'h0000_0002);
    wr(3'd3, 32'h0000_0102);
    step(1);
    chk("R3 active low idle", normReq, 32'h0000_0002);
    chk("R6 normIrq", {31'b0, normIrq}, 32'h1);
    srcIn[1] = 1'b1; srcIn[8] = 1'b1;
    step(2);
    chk("R3 pol no effect internal", normReq, 32'h0000_0100);
  endtask

  task automatic testPendRaw();
    logic [31:0] d;
    cleanSlate();
    srcIn[9] = 1'b1;
    step(1);
    chk("R2 internal level same cycle", normReq, 32'h0);
    rd(3'd6, d); chk("R7 pending raw", d, 32'h0000_0200);
    chk("R7 disabled no request", {31'b0, normIrq}, 32'h0);
  endtask

  task automatic testEdgeAck();
    logic [31:0] d;
    cleanSlate();
    wr(3'd0, 32'h0000_0400); wr(3'd3, 32'h0000_0400);
    @(negedge clk); srcIn[10] = 1'b1;
    @(negedge clk); srcIn[10] = 1'b0;
    chk("R4 internal edge latched", normReq, 32'h0000_0400);
    @(negedge clk); chk("R4 latch holds", normReq, 32'h0000_0400);
    rd(3'd6, d); chk("R4 pending edge", d, 32'h0000_0400);
    ack(5'd10);
    chk("R9 ack clears", normReq, 32'h0);
  endtask

  task automatic testFvec();
    logic [31:0] d;
    cleanSlate();
    wr(3'd1, 32'h4);
    step(3);
    wr(3'd0, 32'h0000_0404);
    wr(3'd2, 32'h0000_0804);
    wr(3'd3, 32'h0000_0C04);
    @(negedge clk); srcIn[2] = 1'b1;
    step(3);
    chk("R4 ext rise ignored in falling mode", {31'b0, fastIrq}, 32'h0);
    srcIn[2] = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R4 ext falling early", {31'b0, fastIrq}, 32'h0);
    @(negedge clk); chk("R4 ext falling on time", {31'b0, fastIrq}, 32'h1);
    srcIn[10] = 1'b1;
    @(negedge clk); srcIn[10] = 1'b0; srcIn[11] = 1'b1;
    wr(3'd7, 32'hCAFE_0040);
    rd(3'd7, d); chk("R8 fvec value", d, 32'hCAFE_0040);
    rd(3'd6, d); chk("R8 only fast edge cleared", d, 32'h0000_0C00);
    chk("R8 fast level kept", {31'b0, fastIrq}, 32'h1);
    srcIn[11] = 1'b0;
    step(1);
    chk("R6 fast drops", {31'b0, fastIrq}, 32'h0);
  endtask

  task automatic testSetWins();
    cleanSlate();
    wr(3'd0, 32'h0000_1000); wr(3'd3, 32'h0000_1000);
    @(negedge clk); srcIn[12] = 1'b1;
    @(negedge clk); srcIn[12] = 1'b0;
    @(negedge clk); ackEn = 1'b1; ackId = 5'd12; srcIn[12] = 1'b1;
    @(negedge clk); ackEn = 1'b0;
    chk("R10 set beats clear", normReq, 32'h0000_1000);
    srcIn[12] = 1'b0;
    ack(5'd12);
    chk("R9 later ack clears", normReq, 32'h0);
  endtask

  task automatic testMultiFast();
    logic [31:0] d;
    cleanSlate();
    wr(3'd2, 32'h30); wr(3'd3, 32'h30);
    srcIn[4] = 1'b1; srcIn[5] = 1'b1;
    step(1); chk("R6 two fast", {31'b0, fastIrq}, 32'h1);
    srcIn[4] = 1'b0;
    step(1); chk("R6 one fast left", {31'b0, fastIrq}, 32'h1);
    chk("R6 none normal", {31'b0, normIrq}, 32'h0);
    srcIn[5] = 1'b0;
    step(1); chk("R6 all fast gone", {31'b0, fastIrq}, 32'h0);
    rd(3'd6, d); chk("R7 pending empty", d, 32'h0);
  endtask

  task automatic testReadTiming();
    wr(3'd7, 32'h1234_5678);
    @(negedge clk); rdEn = 1'b1; addr = 3'd7;
    @(negedge clk); rdEn = 1'b0;
    chk("R11 data next cycle", rdData, 32'h1234_5678);
    @(negedge clk); chk("R11 idle zero", rdData, 32'h0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; srcIn = '0; wrEn = 1'b0; rdEn = 1'b0; ackEn = 1'b0;
    addr = '0; wrData = '0; ackId = '0;
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testEnable();
    testExtLevel();
    testPolarity();
    testPendRaw();
    testEdgeAck();
    testFvec();
    testSetWins();
    testMultiFast();
    testReadTiming();
    finishRun();
  end
endmodule